// File: doc/BRIEF.md
# Multi-Queue Descriptor Fan-Out with Doorbells

This block sits between a packet-classification stage and a consumer processor. For every processed packet it is handed a buffer-descriptor address and a small set of match flags. It copies the address into every result ring whose flag is set, and it always copies it into a recycle ring. There are five rings: buy, sell, market data, management and recycle. One packet can match several filters, so a single input may write several rings in the same cycle.

Each ring is a circular buffer. Its write pointer advances only when the producer side pushes. The consumer reads the head entry through a register window and releases entries by writing a new read pointer. Both pointers can be read at any time, in the style of a shared-memory ring. Every push into a ring sets that ring's doorbell bit in a status register. The bit stays set until software acknowledges it. An interrupt line is raised while any enabled doorbell bit is set.

An input is taken only when every ring it targets has space. While any targeted ring is full, the ready signal stays low and no ring is written, so a partial write can never occur.

Top module: `match_queue_hub`

## Requirements
- R1: After reset, every write and read pointer is 0, every ring reads as empty, the doorbell status and enable registers are 0, and `irq` is low.
- R2: Each accepted input (`in_valid` and `in_ready` high at a clock edge) appends `in_addr` to the recycle ring (ring 4), whatever the match flags are.
- R3: An accepted input also appends `in_addr` to every ring whose bit is set in `in_match`. Bit 0 selects buy (ring 0), bit 1 sell (ring 1), bit 2 market data (ring 2) and bit 3 management (ring 3). Several rings may be written in the same cycle.
- R4: `in_ready` is low exactly when the recycle ring is full or a ring selected by `in_match` is full. While it is low, no ring pointer or entry changes.
- R5: Each ring holds DEPTH entries. The flags register reads bit 0 = empty (occupancy 0) and bit 1 = full (occupancy DEPTH).
- R6: Register address 4*q+0 reads the write pointer of ring q, and writes to it are ignored. Address 4*q+1 is the read pointer, 4*q+2 the head entry and 4*q+3 the flags. Pointers count modulo 2*DEPTH.
- R7: A write to the read pointer takes effect only if its value is below 2*DEPTH and the resulting occupancy (write pointer minus new value, modulo 2*DEPTH) does not exceed the current occupancy. Any other write is ignored. Entries leave each ring in the order they were written.
- R8: Every push into ring q sets bit q of the doorbell status register (address 20). The bit stays set until it is acknowledged.
- R9: Writing to address 20 sets each status bit whose write-data bit is 1. Bits written with 0 are unchanged.
- R10: Writing to address 21 clears each status bit whose write-data bit is 1. If a push into the same ring happens in the same cycle, the bit ends up set.
- R11: Address 22 holds the enable mask. `irq` is high whenever some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A descriptor is offered |
| in_ready | output | 1 | All targeted rings have space |
| in_addr | input | AW | Descriptor address to store |
| in_match | input | 4 | Match flags: buy, sell, market data, management |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Doorbell interrupt |

## Verification
The bench builds the block with DEPTH set to 4, so PW is 3 and the pointers wrap after 8 pushes. With that depth, random traffic regularly fills one ring while another still has room, which exercises the all-or-nothing acceptance rule. The same depth makes pointer wrap-around and read-pointer writes near the full and empty limits come up many times in a run of a few hundred operations. Address and register widths stay at 32 bits, so head entries compare exactly against the stored descriptor addresses.

// File: rtl/mqh_pkg.sv
package mqh_pkg;
  localparam int NQ     = 5;
  localparam int NMATCH = 4;
  localparam int Q_RECYCLE = 4;

  typedef enum logic [1:0] {
    FLD_WP    = 2'd0,
    FLD_RP    = 2'd1,
    FLD_HEAD  = 2'd2,
    FLD_FLAGS = 2'd3
  } field_e;

  localparam logic [4:0] A_STATUS = 5'(NQ * 4);
  localparam logic [4:0] A_ACK    = 5'(NQ * 4 + 1);
  localparam logic [4:0] A_EN     = 5'(NQ * 4 + 2);
endpackage

// File: rtl/ring_queue.sv
// One circular buffer; DEPTH must be a power of two, at least 2.
module ring_queue #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int RW    = 32,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          rp_we,
  input  logic [RW-1:0] rp_wdata,
  output logic [PW-1:0] wp,
  output logic [PW-1:0] rp,
  output logic [AW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int IW = PW - 1;

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW-1:0] occ, occ_new;
  logic          rp_in_range;

  always_comb begin
    occ         = wp_q - rp_q;
    occ_new     = wp_q - rp_wdata[PW-1:0];
    rp_in_range = (rp_wdata[RW-1:PW] == '0);
    wp_d        = wp_q;
    rp_d        = rp_q;
    if (push) wp_d = wp_q + PW'(1);
    if (rp_we && rp_in_range && (occ_new <= occ)) rp_d = rp_wdata[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_d;
      if (rp_we) rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[IW-1:0]] <= push_data;
  end

  assign wp    = wp_q;
  assign rp    = rp_q;
  assign head  = mem[rp_q[IW-1:0]];
  assign full  = (occ == PW'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int NQ = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] hw_set,
  input  logic          set_we,
  input  logic          ack_we,
  input  logic          en_we,
  input  logic [NQ-1:0] wdata,
  output logic [NQ-1:0] status,
  output logic [NQ-1:0] enable,
  output logic          irq
);
  logic [NQ-1:0] st_q, st_d, en_q, en_d;

  always_comb begin
    st_d = st_q;
    if (set_we) st_d = st_d | wdata;
    if (ack_we) st_d = st_d & ~wdata;
    st_d = st_d | hw_set;       // a fresh push beats an acknowledge
    en_d = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      if (en_we) en_q <= en_d;
    end
  end

  assign status = st_q;
  assign enable = en_q;
  assign irq    = |(st_q & en_q);
endmodule

// File: rtl/match_queue_hub.sv
module match_queue_hub
  import mqh_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int RW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [NMATCH-1:0] in_match,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic [NQ-1:0] target, push, rp_we, q_full, q_empty;
  logic [PW-1:0] q_wp   [NQ];
  logic [PW-1:0] q_rp   [NQ];
  logic [AW-1:0] q_head [NQ];
  logic [NQ-1:0] db_status, db_enable;
  logic          accept, in_qreg;
  logic [2:0]    sel_q;
  field_e        fld;

  assign target   = {1'b1, in_match};
  assign in_ready = ~|(target & q_full);
  assign accept   = in_valid & in_ready;
  assign push     = target & {NQ{accept}};

  assign in_qreg = (reg_addr < A_STATUS);
  assign sel_q   = reg_addr[4:2];
  assign fld     = field_e'(reg_addr[1:0]);

  for (genvar g = 0; g < NQ; g++) begin : g_ring
    assign rp_we[g] = reg_we && in_qreg && (sel_q == 3'(g)) && (fld == FLD_RP);

    ring_queue #(.DEPTH(DEPTH), .AW(AW), .RW(RW), .PW(PW)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push[g]),
      .push_data(in_addr),
      .rp_we    (rp_we[g]),
      .rp_wdata (reg_wdata),
      .wp       (q_wp[g]),
      .rp       (q_rp[g]),
      .head     (q_head[g]),
      .full     (q_full[g]),
      .empty    (q_empty[g])
    );
  end

  doorbell_regs #(.NQ(NQ)) u_bell (
    .clk   (clk),
    .rst_n (rst_n),
    .hw_set(push),
    .set_we(reg_we && (reg_addr == A_STATUS)),
    .ack_we(reg_we && (reg_addr == A_ACK)),
    .en_we (reg_we && (reg_addr == A_EN)),
    .wdata (reg_wdata[NQ-1:0]),
    .status(db_status),
    .enable(db_enable),
    .irq   (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_qreg) begin
      case (fld)
        FLD_WP:    reg_rdata[PW-1:0] = q_wp[sel_q];
        FLD_RP:    reg_rdata[PW-1:0] = q_rp[sel_q];
        FLD_HEAD:  reg_rdata         = RW'(q_head[sel_q]);
        FLD_FLAGS: reg_rdata[1:0]    = {q_full[sel_q], q_empty[sel_q]};
        default:   reg_rdata         = '0;
      endcase
    end else if (reg_addr == A_STATUS) begin
      reg_rdata[NQ-1:0] = db_status;
    end else if (reg_addr == A_EN) begin
      reg_rdata[NQ-1:0] = db_enable;
    end
  end
endmodule

// File: rtl/match_queue_hub_chk.sv
module match_queue_hub_chk #(
  parameter int NQ    = 5,
  parameter int PW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [NQ-2:0] in_match,
  input logic          reg_we,
  input logic [NQ-1:0] q_full,
  input logic [PW-1:0] q_wp [NQ],
  input logic [PW-1:0] q_rp [NQ],
  input logic [NQ-1:0] db_status
);
  logic [NQ-1:0] tgt;
  assign tgt = {1'b1, in_match};

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [PW-1:0] occ;
    assign occ = q_wp[i] - q_rp[i];

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH)); // R5
    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> $stable(q_wp[i])); // R4
    AST_TARGET_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && tgt[i]) |=> (q_wp[i] == PW'($past(q_wp[i]) + PW'(1)))); // R3
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && q_full[i] && tgt[i]) |-> !in_ready); // R4
    AST_DOORBELL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && tgt[i]) |=> db_status[i]); // R8
  end

  AST_RECYCLE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (q_wp[NQ-1] != $past(q_wp[NQ-1]))); // R2
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !reg_we) |=> $stable(db_status)); // R8
endmodule

bind match_queue_hub match_queue_hub_chk #(.NQ(mqh_pkg::NQ), .PW(PW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_match (in_match),
  .reg_we   (reg_we),
  .q_full   (q_full),
  .q_wp     (q_wp),
  .q_rp     (q_rp),
  .db_status(db_status)
);

// File: tb/match_queue_hub_bench.sv
module match_queue_hub_bench;
  localparam int D  = 4;
  localparam int PM = 2 * D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, reg_we, irq;
  logic [31:0] in_addr, reg_wdata, reg_rdata;
  logic [3:0]  in_match;
  logic [4:0]  reg_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] mm [5][D];
  int          mwp [5];
  int          mrp [5];
  logic [4:0]  mstat, men;

  always #2 clk = ~clk;

  match_queue_hub #(.DEPTH(D), .AW(32), .RW(32)) u_match_queue_hub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_match(in_match), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic int occ(input int q);
    return mwp[q] - mrp[q];
  endfunction

  function automatic logic exp_ready(input logic [3:0] m);
    logic ok = (occ(4) < D);
    for (int i = 0; i < 4; i++) if (m[i] && occ(i) >= D) ok = 1'b0;
    return ok;
  endfunction

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // one clock with optional push and optional register write; model follows
  task automatic step(input logic v, input logic [31:0] a, input logic [3:0] m,
                      input logic we, input logic [4:0] ra, input logic [31:0] wd);
    logic acc;
    @(negedge clk);
    in_valid = v; in_addr = a; in_match = m;
    reg_we = we; reg_addr = ra; reg_wdata = wd;
    #1;
    if (v) chk("R4 ready", 32'(in_ready), 32'(exp_ready(m)));
    acc = v && in_ready;
    @(posedge clk);
    #1;
    in_valid = 1'b0; reg_we = 1'b0;
    if (we) begin
      if (ra < 5'd20 && ra[1:0] == 2'd1) begin
        int q = int'(ra[4:2]);
        if (wd < 32'(PM)) begin
          int nw = ((mwp[q] % PM) - int'(wd) + PM) % PM;
          if (nw <= occ(q)) mrp[q] = mwp[q] - nw;
        end
      end else if (ra == 5'd20) mstat = mstat | wd[4:0];
      else if (ra == 5'd21) mstat = mstat & ~wd[4:0];
      else if (ra == 5'd22) men = wd[4:0];
    end
    if (acc) begin
      logic [4:0] t = {1'b1, m};
      for (int q = 0; q < 5; q++) if (t[q]) begin
        mm[q][mwp[q] % D] = a;
        mwp[q]++;
        mstat[q] = 1'b1;
      end
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [3:0] m);
    step(1'b1, a, m, 1'b0, 5'd0, 32'd0);
  endtask

  task automatic wr(input logic [4:0] ra, input logic [31:0] wd);
    step(1'b0, 32'd0, 4'd0, 1'b1, ra, wd);
  endtask

  task automatic check_ptrs();
    logic [31:0] d;
    for (int q = 0; q < 5; q++) begin
      rd(5'(q * 4), d);     chk("R3 wp", d, 32'(mwp[q] % PM));
      rd(5'(q * 4 + 1), d); chk("R7 rp", d, 32'(mrp[q] % PM));
    end
  endtask

  task automatic check_bell();
    logic [31:0] d;
    rd(5'd20, d);
    chk("R8 status", d, 32'(mstat));
    chk("R11 irq", 32'(irq), 32'(|(mstat & men)));
  endtask

  task automatic pop(input int q);
    logic [31:0] d;
    if (occ(q) > 0) begin
      rd(5'(q * 4 + 2), d);
      chk("R7 head order", d, mm[q][mrp[q] % D]);
      wr(5'(q * 4 + 1), 32'((mrp[q] + 1) % PM));
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    in_valid = 0; in_addr = 0; in_match = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    for (int q = 0; q < 5; q++) begin mwp[q] = 0; mrp[q] = 0; end
    mstat = 0; men = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int q = 0; q < 5; q++) begin
      rd(5'(q * 4), d);     chk("R1 wp", d, 0);
      rd(5'(q * 4 + 1), d); chk("R1 rp", d, 0);
      rd(5'(q * 4 + 3), d); chk("R1 flags", d, 32'd1);
    end
    rd(5'd20, d); chk("R1 status", d, 0);
    rd(5'd22, d); chk("R1 enable", d, 0);
    chk("R1 irq", 32'(irq), 0);

    wr(5'd22, 32'h1F);
    rd(5'd22, d); chk("R11 enable", d, 32'h1F);

    // R2 no match still lands in recycle
    push(32'h0000_1000, 4'b0000);
    check_ptrs();
    rd(5'd18, d); chk("R2 recycle head", d, 32'h0000_1000);
    check_bell();

    // R3 two filters in one operation
    push(32'h0000_2000, 4'b0101);
    check_ptrs();
    rd(5'd2, d);  chk("R3 buy head", d, 32'h0000_2000);
    rd(5'd10, d); chk("R3 mdata head", d, 32'h0000_2000);
    check_bell();

    // drain everything
    for (int q = 0; q < 5; q++) while (occ(q) > 0) pop(q);
    check_ptrs();

    // R5 fill buy ring to full
    for (int k = 0; k < D; k++) push(32'h0000_3000 + 32'(k), 4'b0001);
    rd(5'd3, d); chk("R5 buy full flag", d, 32'd2);
    rd(5'd19, d); chk("R5 recycle full flag", d, 32'd2);
    push(32'hDEAD_0000, 4'b0000);      // R4 recycle full blocks
    check_ptrs();
    while (occ(4) > 0) pop(4);
    push(32'h0000_4000, 4'b0000);      // buy full does not matter
    push(32'hDEAD_0001, 4'b0011);      // R4 buy full blocks, no partial
    check_ptrs();

    // R7 illegal read pointer writes
    wr(5'd1, 32'((mwp[0] + 1) % PM));  // passes write pointer
    check_ptrs();
    wr(5'd1, 32'(PM + (mrp[0] % PM))); // out of range
    check_ptrs();
    wr(5'd1, 32'(mwp[0] % PM));        // legal: release all
    rd(5'd3, d); chk("R5 buy empty flag", d, 32'd1);
    wr(5'd1, 32'((mwp[0] + PM - 2) % PM)); // moves backwards
    check_ptrs();

    // R6 write pointer is read-only
    wr(5'd8, 32'd3);
    check_ptrs();

    // R9 software set, R10 ack, R11 mask
    wr(5'd21, 32'h1F);
    check_bell();
    wr(5'd20, 32'h06);
    check_bell();
    wr(5'd21, 32'h02);
    check_bell();
    step(1'b1, 32'h0000_5000, 4'b0000, 1'b1, 5'd21, 32'h10); // R10 set wins
    rd(5'd20, d); chk("R10 set beats ack", d[4], 1'b1);
    wr(5'd22, 32'h01);
    check_bell();
    wr(5'd22, 32'h00);
    chk("R11 masked irq", 32'(irq), 0);
    wr(5'd22, 32'h1F);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 8;
      if (r < 3) push($urandom, 4'($urandom));
      else if (r < 6) pop($urandom % 5);
      else if (r == 6) wr(5'd21, 32'($urandom % 32));
      else wr(5'($urandom % 5 * 4 + 1), 32'($urandom % 10));
      check_bell();
      if (it % 8 == 0) check_ptrs();
    end
    check_ptrs();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule